// File: doc/BRIEF.md
# Tagged Multi-Level Translation Cache

This block caches address translations for an I/O memory management unit. Each of its entries records one finished table walk: the address-space identifier, the input address cut down to the size covered by the walk's final level, the granule code, that level, the output base address and a two-bit permission field. A lookup gives an identifier, an input address, a granule code and the input-size field of the walk. The cache returns, one cycle later, a hit with the translated address, the address mask and the permissions, or a miss.

Every table level the walk could finish on is probed at once, from the walk's starting level down to level 3. Each level uses its own alignment mask, and the shallowest matching level wins. The walk engine writes results in through the insert port. The invalidate port can drop every entry, drop the entries of one identifier, or drop the entries that overlap an address range. The range form tries an exact tag match first when a level hint is given. Two counters record how many lookups hit and how many missed.

Top module: `iotlb_cache`

## Requirements
- R1: A lookup presented with `lk_valid` high gives `rs_valid` high on the next cycle only. On a hit, `rs_oaddr` is the entry's output base ORed with the lookup address bits under `rs_mask`, and `rs_perm` and `rs_level` come from the same entry.
- R2: A hit requires the identifier, the granule code, the level and the lookup address aligned to that level's size to all equal the entry's. The granule code is 1, 2 or 3 for 4 KB, 16 KB or 64 KB granules, and code 0 counts as 4 KB. With g = log2 of the granule, a level-L entry covers 2^(g + (3−L)(g−3)) bytes.
- R3: The starting level is 4 − (60 − tsz) / (g − 3), using integer division and clamped to 0..3. An entry whose level lies above the starting level (a shallower level) is never returned.
- R4: When entries at several levels match, the one with the lowest level number is returned.
- R5: An insert stores the input address aligned to its level size, in the lowest-numbered free slot. If an entry already holds the same tag, that entry is overwritten in place and nothing else changes.
- R6: An insert with a new tag into a cache with every slot valid drops all entries in the same cycle and leaves only the new entry valid.
- R7: Invalidate kind 0 drops every entry.
- R8: Invalidate kind 1 drops every entry whose identifier equals `inv_asid` and keeps the others.
- R9: Invalidate kind 2 builds the range mask (pages << g) − 1. It drops an entry when (inv_addr & ~entry_mask) equals the entry address, or when (entry_addr & ~range_mask) equals inv_addr. With `inv_any_asid` high the identifier is ignored; otherwise entries with another identifier are kept.
- R10: For kind 2 with a nonzero level hint, one page and a specific identifier, entries whose tag exactly equals {inv_asid, inv_addr, inv_gcode, hint} are dropped. Only when none exists does the rule of R9 apply. An exact removal therefore leaves larger covering entries in place.
- R11: Every lookup adds one to `hit_count` or to `miss_count`, according to its result.
- R12: After reset no entry is valid, both counters read zero and `rs_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_addr | input | ADDR_W | Lookup input address |
| lk_gcode | input | 2 | Lookup granule code |
| lk_tsz | input | 6 | Walk input-size field |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Result is a hit |
| rs_oaddr | output | ADDR_W | Translated address |
| rs_mask | output | ADDR_W | Offset mask of the hit entry |
| rs_perm | output | PERM_W | Permission bits of the hit entry |
| rs_level | output | 2 | Level of the hit entry |
| ins_valid | input | 1 | Insert request |
| ins_asid | input | ASID_W | Insert identifier |
| ins_iaddr | input | ADDR_W | Insert input address (aligned inside) |
| ins_oaddr | input | ADDR_W | Insert output base |
| ins_gcode | input | 2 | Insert granule code |
| ins_level | input | 2 | Insert level |
| ins_perm | input | PERM_W | Insert permissions |
| inv_valid | input | 1 | Invalidate request (wins over an insert in the same cycle) |
| inv_kind | input | 2 | 0 all, 1 by identifier, 2 by range |
| inv_asid | input | ASID_W | Invalidate identifier |
| inv_any_asid | input | 1 | Range invalidate ignores identifier |
| inv_addr | input | ADDR_W | Range invalidate address |
| inv_gcode | input | 2 | Range invalidate granule code |
| inv_pages | input | PAGE_W | Range invalidate page count |
| inv_level_hint | input | 2 | Level hint, 0 for none |
| hit_count | output | CNT_W | Lookups that hit |
| miss_count | output | CNT_W | Lookups that missed |

## Verification
The bench places a 1 GB block and a 4 KB page over the same address. It then checks that a deep starting level skips the block, and that a shallow starting level returns the block. A design that ignored the starting level or preferred the deeper entry would return the wrong translation. The exact-tag invalidation is checked by confirming that the covering 2 MB block survives while the page is gone. A design that always ran the range rule would lose the block, and one that never did would keep stale pages. Range invalidation is checked with an address-space wildcard and with a mismatched identifier. Filling all sixteen slots and then inserting once more shows whether the whole array is flushed, and re-inserting an existing tag shows that no flush and no duplicate happen.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

   localparam int LVL_W = 2;
   localparam int GC_W  = 2;
   localparam int TSZ_W = 6;

   typedef enum logic [1:0] {
      INV_ALL   = 2'd0,
      INV_ASID  = 2'd1,
      INV_RANGE = 2'd2
   } inv_kind_e;

   // log2 of the granule; code 0 is treated as 4 KB
   function automatic int gran_log2(logic [GC_W-1:0] gc);
      return (gc == '0) ? 12 : 2 * int'(gc) + 10;
   endfunction

   function automatic int lvl_shift(logic [GC_W-1:0] gc, logic [LVL_W-1:0] lvl);
      int g;
      g = gran_log2(gc);
      return g + (3 - int'(lvl)) * (g - 3);
   endfunction

   function automatic logic [63:0] low_mask(int sh);
      return (64'd1 << sh) - 64'd1;
   endfunction

   function automatic logic [LVL_W-1:0] first_level(logic [GC_W-1:0] gc,
                                                    logic [TSZ_W-1:0] tsz);
      int isz, st, l;
      isz = 64 - int'(tsz);
      st  = gran_log2(gc) - 3;
      l   = 4 - (isz - 4) / st;
      if (l < 0) l = 0;
      if (l > 3) l = 3;
      return LVL_W'(l);
   endfunction

endpackage

// File: rtl/iotlb_probe.sv
module iotlb_probe
   import iotlb_pkg::*;
#(
   parameter int N      = 16,
   parameter int ASID_W = 16,
   parameter int ADDR_W = 64
) (
   input  logic [N-1:0]                 vld,
   input  logic [N-1:0][ASID_W-1:0]     e_asid,
   input  logic [N-1:0][ADDR_W-1:0]     e_iaddr,
   input  logic [N-1:0][GC_W-1:0]       e_gc,
   input  logic [N-1:0][LVL_W-1:0]      e_lvl,
   input  logic [ASID_W-1:0]            q_asid,
   input  logic [ADDR_W-1:0]            q_addr,
   input  logic [GC_W-1:0]              q_gc,
   input  logic [LVL_W-1:0]             q_start,
   output logic [N-1:0]                 hit
);
   for (genvar i = 0; i < N; i++) begin : g_ent
      logic [63:0] m64;
      logic [ADDR_W-1:0] m;
      assign m64 = low_mask(lvl_shift(e_gc[i], e_lvl[i]));
      assign m   = m64[ADDR_W-1:0];
      assign hit[i] = vld[i] && (e_asid[i] == q_asid) && (e_gc[i] == q_gc)
                   && (e_lvl[i] >= q_start) && (e_iaddr[i] == (q_addr & ~m));
   end
endmodule

// File: rtl/iotlb_slot_pick.sv
module iotlb_slot_pick
   import iotlb_pkg::*;
#(
   parameter int N      = 16,
   parameter int ASID_W = 16,
   parameter int ADDR_W = 64,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]                 vld,
   input  logic [N-1:0][ASID_W-1:0]     e_asid,
   input  logic [N-1:0][ADDR_W-1:0]     e_iaddr,
   input  logic [N-1:0][GC_W-1:0]       e_gc,
   input  logic [N-1:0][LVL_W-1:0]      e_lvl,
   input  logic [ASID_W-1:0]            n_asid,
   input  logic [ADDR_W-1:0]            n_iaddr,
   input  logic [GC_W-1:0]              n_gc,
   input  logic [LVL_W-1:0]             n_lvl,
   output logic                         dup,
   output logic [IDX_W-1:0]             dup_idx,
   output logic                         full,
   output logic [IDX_W-1:0]             free_idx
);
   logic [N-1:0] same;

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign same[i] = vld[i] && (e_asid[i] == n_asid) && (e_gc[i] == n_gc)
                    && (e_lvl[i] == n_lvl) && (e_iaddr[i] == n_iaddr);
   end

   always_comb begin
      dup      = 1'b0;
      dup_idx  = '0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!vld[i]) free_idx = IDX_W'(i);
         if (same[i]) begin
            dup     = 1'b1;
            dup_idx = IDX_W'(i);
         end
      end
      full = &vld;
   end
endmodule

// File: rtl/iotlb_inv_sel.sv
module iotlb_inv_sel
   import iotlb_pkg::*;
#(
   parameter int N      = 16,
   parameter int ASID_W = 16,
   parameter int ADDR_W = 64,
   parameter int PAGE_W = 16
) (
   input  logic [N-1:0]                 vld,
   input  logic [N-1:0][ASID_W-1:0]     e_asid,
   input  logic [N-1:0][ADDR_W-1:0]     e_iaddr,
   input  logic [N-1:0][GC_W-1:0]       e_gc,
   input  logic [N-1:0][LVL_W-1:0]      e_lvl,
   input  logic [1:0]                   kind,
   input  logic [ASID_W-1:0]            asid,
   input  logic                         any_asid,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [GC_W-1:0]              gc,
   input  logic [PAGE_W-1:0]            pages,
   input  logic [LVL_W-1:0]             hint,
   output logic [N-1:0]                 kill
);
   logic [63:0]       rm64;
   logic [ADDR_W-1:0] rmask;
   logic [N-1:0]      exact, ovl, same_id;
   logic              try_exact;

   assign rm64  = (64'(pages) << gran_log2(gc)) - 64'd1;
   assign rmask = rm64[ADDR_W-1:0];
   assign try_exact = (hint != '0) && (pages == PAGE_W'(1)) && !any_asid;

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic [63:0] em64;
      logic [ADDR_W-1:0] em;
      assign em64 = low_mask(lvl_shift(e_gc[i], e_lvl[i]));
      assign em   = em64[ADDR_W-1:0];
      assign same_id[i] = vld[i] && (e_asid[i] == asid);
      assign exact[i] = same_id[i] && (e_gc[i] == gc) && (e_lvl[i] == hint)
                     && (e_iaddr[i] == addr);
      assign ovl[i] = vld[i] && (any_asid || same_id[i])
                   && (((addr & ~em) == e_iaddr[i]) || ((e_iaddr[i] & ~rmask) == addr));
   end

   always_comb begin
      unique case (inv_kind_e'(kind))
         INV_ALL:   kill = vld;
         INV_ASID:  kill = same_id;
         INV_RANGE: kill = (try_exact && (|exact)) ? exact : ovl;
         default:   kill = '0;
      endcase
   end
endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
   import iotlb_pkg::*;
#(
   parameter int N      = 16,
   parameter int ASID_W = 16,
   parameter int ADDR_W = 64,
   parameter int PERM_W = 2,
   parameter int PAGE_W = 16,
   parameter int CNT_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lk_valid,
   input  logic [ASID_W-1:0]    lk_asid,
   input  logic [ADDR_W-1:0]    lk_addr,
   input  logic [1:0]           lk_gcode,
   input  logic [5:0]           lk_tsz,
   output logic                 rs_valid,
   output logic                 rs_hit,
   output logic [ADDR_W-1:0]    rs_oaddr,
   output logic [ADDR_W-1:0]    rs_mask,
   output logic [PERM_W-1:0]    rs_perm,
   output logic [1:0]           rs_level,
   input  logic                 ins_valid,
   input  logic [ASID_W-1:0]    ins_asid,
   input  logic [ADDR_W-1:0]    ins_iaddr,
   input  logic [ADDR_W-1:0]    ins_oaddr,
   input  logic [1:0]           ins_gcode,
   input  logic [1:0]           ins_level,
   input  logic [PERM_W-1:0]    ins_perm,
   input  logic                 inv_valid,
   input  logic [1:0]           inv_kind,
   input  logic [ASID_W-1:0]    inv_asid,
   input  logic                 inv_any_asid,
   input  logic [ADDR_W-1:0]    inv_addr,
   input  logic [1:0]           inv_gcode,
   input  logic [PAGE_W-1:0]    inv_pages,
   input  logic [1:0]           inv_level_hint,
   output logic [CNT_W-1:0]     hit_count,
   output logic [CNT_W-1:0]     miss_count
);
   localparam int IDX_W = $clog2(N);

   if (N < 2 || (1 << IDX_W) != N) begin : g_bad_n
      $error("iotlb_cache: N must be a power of two of at least 2");
   end
   if (ADDR_W < 56 || ADDR_W > 64) begin : g_bad_addr
      $error("iotlb_cache: ADDR_W must lie in 56..64");
   end
   if (CNT_W < 1 || PAGE_W < 1 || PERM_W < 1) begin : g_bad_w
      $error("iotlb_cache: widths must be positive");
   end

   logic [N-1:0]               vld, nxt_vld, kill;
   logic [N-1:0][ASID_W-1:0]   e_asid;
   logic [N-1:0][ADDR_W-1:0]   e_iaddr, e_oaddr;
   logic [N-1:0][GC_W-1:0]     e_gc;
   logic [N-1:0][LVL_W-1:0]    e_lvl;
   logic [N-1:0][PERM_W-1:0]   e_perm;

   // ---------------- lookup ----------------
   logic [N-1:0]     hitv;
   logic [LVL_W-1:0] q_start;
   logic             found;
   logic [IDX_W-1:0] sel;
   logic [63:0]      sel_m64;
   logic [ADDR_W-1:0] sel_mask;

   assign q_start = first_level(lk_gcode, lk_tsz);

   iotlb_probe #(.N(N), .ASID_W(ASID_W), .ADDR_W(ADDR_W)) u_probe (
      .vld(vld), .e_asid(e_asid), .e_iaddr(e_iaddr), .e_gc(e_gc), .e_lvl(e_lvl),
      .q_asid(lk_asid), .q_addr(lk_addr), .q_gc(lk_gcode), .q_start(q_start),
      .hit(hitv));

   // shallowest level first, lowest slot within a level
   always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int l = 0; l < 4; l++) begin
         for (int i = 0; i < N; i++) begin
            if (!found && hitv[i] && (e_lvl[i] == LVL_W'(l))) begin
               found = 1'b1;
               sel   = IDX_W'(i);
            end
         end
      end
   end

   assign sel_m64  = low_mask(lvl_shift(e_gc[sel], e_lvl[sel]));
   assign sel_mask = sel_m64[ADDR_W-1:0];

   // ---------------- insert ----------------
   logic [63:0]       ins_m64;
   logic [ADDR_W-1:0] ins_aligned;
   logic              dup, full, ins_go, flush_ins;
   logic [IDX_W-1:0]  dup_idx, free_idx, wr_idx;

   assign ins_m64     = low_mask(lvl_shift(ins_gcode, ins_level));
   assign ins_aligned = ins_iaddr & ~ins_m64[ADDR_W-1:0];

   iotlb_slot_pick #(.N(N), .ASID_W(ASID_W), .ADDR_W(ADDR_W)) u_pick (
      .vld(vld), .e_asid(e_asid), .e_iaddr(e_iaddr), .e_gc(e_gc), .e_lvl(e_lvl),
      .n_asid(ins_asid), .n_iaddr(ins_aligned), .n_gc(ins_gcode), .n_lvl(ins_level),
      .dup(dup), .dup_idx(dup_idx), .full(full), .free_idx(free_idx));

   assign ins_go    = ins_valid && !inv_valid;
   assign flush_ins = ins_go && full && !dup;
   assign wr_idx    = dup ? dup_idx : (full ? '0 : free_idx);

   // ---------------- invalidate ----------------
   iotlb_inv_sel #(.N(N), .ASID_W(ASID_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_inv (
      .vld(vld), .e_asid(e_asid), .e_iaddr(e_iaddr), .e_gc(e_gc), .e_lvl(e_lvl),
      .kind(inv_kind), .asid(inv_asid), .any_asid(inv_any_asid), .addr(inv_addr),
      .gc(inv_gcode), .pages(inv_pages), .hint(inv_level_hint), .kill(kill));

   always_comb begin
      logic [N-1:0] wr_oh;
      wr_oh = {{(N-1){1'b0}}, 1'b1} << wr_idx;
      if (inv_valid)      nxt_vld = vld & ~kill;
      else if (flush_ins) nxt_vld = wr_oh;
      else if (ins_go)    nxt_vld = vld | wr_oh;
      else                nxt_vld = vld;
   end

   // ---------------- state ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld        <= '0;
         rs_valid   <= 1'b0;
         rs_hit     <= 1'b0;
         rs_oaddr   <= '0;
         rs_mask    <= '0;
         rs_perm    <= '0;
         rs_level   <= '0;
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         vld      <= nxt_vld;
         rs_valid <= lk_valid;
         if (lk_valid) begin
            rs_hit   <= found;
            rs_oaddr <= found ? (e_oaddr[sel] | (lk_addr & sel_mask)) : '0;
            rs_mask  <= found ? sel_mask : '0;
            rs_perm  <= found ? e_perm[sel] : '0;
            rs_level <= found ? e_lvl[sel] : '0;
            if (found) hit_count  <= hit_count + CNT_W'(1);
            else       miss_count <= miss_count + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (ins_go) begin
         e_asid[wr_idx]  <= ins_asid;
         e_iaddr[wr_idx] <= ins_aligned;
         e_oaddr[wr_idx] <= ins_oaddr;
         e_gc[wr_idx]    <= ins_gcode;
         e_lvl[wr_idx]   <= ins_level;
         e_perm[wr_idx]  <= ins_perm;
      end
   end
endmodule

// File: rtl/iotlb_cache_chk.sv
module iotlb_cache_chk
   import iotlb_pkg::*;
#(
   parameter int N      = 16,
   parameter int ADDR_W = 64,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [ADDR_W-1:0] lk_addr,
   input logic [1:0]        lk_gcode,
   input logic [5:0]        lk_tsz,
   input logic              rs_valid,
   input logic              rs_hit,
   input logic [ADDR_W-1:0] rs_oaddr,
   input logic [ADDR_W-1:0] rs_mask,
   input logic [1:0]        rs_level,
   input logic              inv_valid,
   input logic [1:0]        inv_kind,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  miss_count,
   input logic [N-1:0]      vld,
   input logic              flush_ins
);
   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);  // R1
   AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rs_valid);  // R1
   AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      rs_hit |-> (((rs_oaddr ^ $past(lk_addr)) & rs_mask) == '0));  // R1
   AST_HIT_LEVEL_START: assert property (@(posedge clk) disable iff (!rst_n)
      rs_hit |-> (rs_level >= first_level($past(lk_gcode), $past(lk_tsz))));  // R3
   AST_FULL_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
      flush_ins |=> ($countones(vld) == 1));  // R6
   AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && inv_kind == 2'd0) |=> (vld == '0));  // R7
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> ({1'b0, hit_count} + {1'b0, miss_count}
                    == $past({1'b0, hit_count} + {1'b0, miss_count}) + (CNT_W+1)'(1)));  // R11
   AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> ($stable(hit_count) && $stable(miss_count)));  // R11
endmodule

bind iotlb_cache iotlb_cache_chk #(.N(N), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
   .lk_gcode(lk_gcode), .lk_tsz(lk_tsz), .rs_valid(rs_valid), .rs_hit(rs_hit),
   .rs_oaddr(rs_oaddr), .rs_mask(rs_mask), .rs_level(rs_level),
   .inv_valid(inv_valid), .inv_kind(inv_kind), .hit_count(hit_count),
   .miss_count(miss_count), .vld(vld), .flush_ins(flush_ins));

// File: tb/iotlb_cache_bench.sv
module iotlb_cache_bench;
   localparam int ASID_W = 16;
   localparam int ADDR_W = 64;
   localparam int PERM_W = 2;
   localparam int PAGE_W = 16;
   localparam int CNT_W  = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;  // 200 MHz

   logic               lk_valid = 0;
   logic [ASID_W-1:0]  lk_asid = 0;
   logic [ADDR_W-1:0]  lk_addr = 0;
   logic [1:0]         lk_gcode = 0;
   logic [5:0]         lk_tsz = 0;
   logic               rs_valid, rs_hit;
   logic [ADDR_W-1:0]  rs_oaddr, rs_mask;
   logic [PERM_W-1:0]  rs_perm;
   logic [1:0]         rs_level;
   logic               ins_valid = 0;
   logic [ASID_W-1:0]  ins_asid = 0;
   logic [ADDR_W-1:0]  ins_iaddr = 0, ins_oaddr = 0;
   logic [1:0]         ins_gcode = 0, ins_level = 0;
   logic [PERM_W-1:0]  ins_perm = 0;
   logic               inv_valid = 0;
   logic [1:0]         inv_kind = 0;
   logic [ASID_W-1:0]  inv_asid = 0;
   logic               inv_any_asid = 0;
   logic [ADDR_W-1:0]  inv_addr = 0;
   logic [1:0]         inv_gcode = 0;
   logic [PAGE_W-1:0]  inv_pages = 0;
   logic [1:0]         inv_level_hint = 0;
   logic [CNT_W-1:0]   hit_count, miss_count;

   iotlb_cache #(.N(16), .ASID_W(ASID_W), .ADDR_W(ADDR_W), .PERM_W(PERM_W),
                 .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_iotlb_cache (.*);

   typedef struct {
      logic              hit;
      logic [ADDR_W-1:0] oaddr;
      logic [ADDR_W-1:0] mask;
      logic [PERM_W-1:0] perm;
      string             tag;
   } exp_t;

   exp_t q[$];
   int checks = 0, fails = 0;
   int exp_hits = 0, exp_miss = 0;

   // ---------------- driver tasks ----------------
   task automatic do_ins(input logic [ASID_W-1:0] a, input logic [ADDR_W-1:0] ia,
                         input logic [ADDR_W-1:0] oa, input logic [1:0] gc,
                         input logic [1:0] lv, input logic [PERM_W-1:0] p);
      @(negedge clk);
      ins_asid = a; ins_iaddr = ia; ins_oaddr = oa; ins_gcode = gc;
      ins_level = lv; ins_perm = p; ins_valid = 1'b1;
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic do_inv(input logic [1:0] k, input logic [ASID_W-1:0] a, input logic any,
                         input logic [ADDR_W-1:0] ad, input logic [1:0] gc,
                         input logic [PAGE_W-1:0] pg, input logic [1:0] h);
      @(negedge clk);
      inv_kind = k; inv_asid = a; inv_any_asid = any; inv_addr = ad;
      inv_gcode = gc; inv_pages = pg; inv_level_hint = h; inv_valid = 1'b1;
      @(negedge clk);
      inv_valid = 1'b0;
   endtask

   task automatic do_look(input logic [ASID_W-1:0] a, input logic [ADDR_W-1:0] ad,
                          input logic [1:0] gc, input logic [5:0] tsz,
                          input logic eh, input logic [ADDR_W-1:0] eo,
                          input logic [ADDR_W-1:0] em, input logic [PERM_W-1:0] ep,
                          input string tag);
      exp_t e;
      e.hit = eh; e.oaddr = eo; e.mask = em; e.perm = ep; e.tag = tag;
      @(negedge clk);
      q.push_back(e);
      if (eh) exp_hits++; else exp_miss++;
      lk_asid = a; lk_addr = ad; lk_gcode = gc; lk_tsz = tsz; lk_valid = 1'b1;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic miss(input logic [ASID_W-1:0] a, input logic [ADDR_W-1:0] ad,
                       input logic [1:0] gc, input logic [5:0] tsz, input string tag);
      do_look(a, ad, gc, tsz, 1'b0, '0, '0, '0, tag);
   endtask

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      if (rst_n && rs_valid) begin
         checks++;
         if (q.size() == 0) begin
            fails++;
            $display("FAIL R1: result without request, hit=%0b expected none", rs_hit);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (rs_hit !== e.hit ||
                (e.hit && (rs_oaddr !== e.oaddr || rs_mask !== e.mask || rs_perm !== e.perm))) begin
               fails++;
               $display("FAIL %s: hit=%0b oaddr=%h mask=%h perm=%0d expected hit=%0b oaddr=%h mask=%h perm=%0d",
                        e.tag, rs_hit, rs_oaddr, rs_mask, rs_perm, e.hit, e.oaddr, e.mask, e.perm);
            end
         end
      end
   end

   task automatic check_eq(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   localparam logic [63:0] M4K  = 64'hFFF;
   localparam logic [63:0] M16K = 64'h3FFF;
   localparam logic [63:0] M2M  = 64'h1F_FFFF;
   localparam logic [63:0] M1G  = 64'h3FFF_FFFF;

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R12 rs_valid", rs_valid, 0);
      check_eq("R12 hit_count", hit_count, 0);
      check_eq("R12 miss_count", miss_count, 0);
      miss(16'd5, 64'h1234_5678_9ABC, 2'd1, 6'd16, "R12");

      // 4 KB page, unaligned insert address
      do_ins(16'd5, 64'h1234_5678_9ABC, 64'h8000_0000, 2'd1, 2'd3, 2'd3);
      do_look(16'd5, 64'h1234_5678_9ABC, 2'd1, 6'd16, 1, 64'h8000_0ABC, M4K, 2'd3, "R1");
      miss(16'd6, 64'h1234_5678_9ABC, 2'd1, 6'd16, "R2");
      miss(16'd5, 64'h1234_5678_9ABC, 2'd3, 6'd16, "R2");

      // 2 MB block
      do_ins(16'd5, 64'h4021_2345, 64'h9000_0000, 2'd1, 2'd2, 2'd1);
      do_look(16'd5, 64'h4023_4567, 2'd1, 6'd16, 1, 64'h9003_4567, M2M, 2'd1, "R5");

      // 16 KB granule page
      do_ins(16'd3, 64'h1_2345_6789, 64'h5_0000_0000, 2'd2, 2'd3, 2'd2);
      do_look(16'd3, 64'h1_2345_7FFF, 2'd2, 6'd16, 1, 64'h5_0000_3FFF, M16K, 2'd2, "R2");
      miss(16'd3, 64'h1_2345_7FFF, 2'd1, 6'd16, "R2");

      // 1 GB block over a 4 KB page
      do_ins(16'd7, 64'h8000_0000, 64'h1_0000_0000, 2'd1, 2'd1, 2'd2);
      do_ins(16'd7, 64'h8000_5000, 64'h2_0000_0000, 2'd1, 2'd3, 2'd1);
      do_look(16'd7, 64'h8000_5010, 2'd1, 6'd16, 1, 64'h1_0000_5010, M1G, 2'd2, "R4");
      do_look(16'd7, 64'h8000_5010, 2'd1, 6'd34, 1, 64'h2_0000_0010, M4K, 2'd1, "R3");
      miss(16'd7, 64'h8000_9000, 2'd1, 6'd34, "R3");

      // invalidate by identifier
      do_inv(2'd1, 16'd7, 0, '0, 2'd0, '0, 2'd0);
      miss(16'd7, 64'h8000_5010, 2'd1, 6'd16, "R8");
      do_look(16'd5, 64'h1234_5678_9123, 2'd1, 6'd16, 1, 64'h8000_0123, M4K, 2'd3, "R8");

      // exact-tag removal keeps the covering block
      do_ins(16'd5, 64'h4020_3000, 64'hA000_0000, 2'd1, 2'd3, 2'd3);
      do_inv(2'd2, 16'd5, 0, 64'h4020_3000, 2'd1, 16'd1, 2'd3);
      do_look(16'd5, 64'h4020_3004, 2'd1, 6'd16, 1, 64'h9000_3004, M2M, 2'd1, "R10");
      // no exact tag: fall back to range rule, block removed
      do_inv(2'd2, 16'd5, 0, 64'h4020_7000, 2'd1, 16'd1, 2'd3);
      miss(16'd5, 64'h4020_3004, 2'd1, 6'd16, "R10");
      do_look(16'd3, 64'h1_2345_4001, 2'd2, 6'd16, 1, 64'h5_0000_0001, M16K, 2'd2, "R10");

      // range with identifier wildcard, granule code 0, two pages
      do_ins(16'd9,  64'h7000_0000, 64'hB000_0000, 2'd1, 2'd3, 2'd3);
      do_ins(16'd10, 64'h7000_1000, 64'hB000_1000, 2'd1, 2'd3, 2'd3);
      do_ins(16'd11, 64'h7000_2000, 64'hB000_2000, 2'd1, 2'd3, 2'd3);
      do_inv(2'd2, 16'd0, 1, 64'h7000_0000, 2'd0, 16'd2, 2'd0);
      miss(16'd9,  64'h7000_0000, 2'd1, 6'd16, "R9");
      miss(16'd10, 64'h7000_1000, 2'd1, 6'd16, "R9");
      do_look(16'd11, 64'h7000_2008, 2'd1, 6'd16, 1, 64'hB000_2008, M4K, 2'd3, "R9");
      do_inv(2'd2, 16'd12, 0, 64'h7000_2000, 2'd1, 16'd1, 2'd0);
      do_look(16'd11, 64'h7000_2010, 2'd1, 6'd16, 1, 64'hB000_2010, M4K, 2'd3, "R9");

      // invalidate all
      do_inv(2'd0, 16'd0, 0, '0, 2'd0, '0, 2'd0);
      miss(16'd5, 64'h1234_5678_9ABC, 2'd1, 6'd16, "R7");
      miss(16'd11, 64'h7000_2010, 2'd1, 6'd16, "R7");

      // fill all sixteen slots
      for (int i = 0; i < 16; i++)
         do_ins(16'd20, 64'(i) << 12, (64'(i) + 64'h100) << 12, 2'd1, 2'd3, 2'd1);
      do_look(16'd20, 64'h0004, 2'd1, 6'd16, 1, 64'h10_0004, M4K, 2'd1, "R6");
      do_look(16'd20, 64'hF004, 2'd1, 6'd16, 1, 64'h10_F004, M4K, 2'd1, "R6");
      // same tag re-inserted: overwrite, no flush
      do_ins(16'd20, 64'h3456, 64'hDEAD_0000, 2'd1, 2'd3, 2'd2);
      do_look(16'd20, 64'h3123, 2'd1, 6'd16, 1, 64'hDEAD_0123, M4K, 2'd2, "R5");
      do_look(16'd20, 64'h0008, 2'd1, 6'd16, 1, 64'h10_0008, M4K, 2'd1, "R5");
      // new tag into full cache: flush then insert
      do_ins(16'd20, 64'h10_0000, 64'hC000_0000, 2'd1, 2'd3, 2'd3);
      miss(16'd20, 64'h0008, 2'd1, 6'd16, "R6");
      miss(16'd20, 64'hF008, 2'd1, 6'd16, "R6");
      do_look(16'd20, 64'h10_0ABC, 2'd1, 6'd16, 1, 64'hC000_0ABC, M4K, 2'd3, "R6");

      repeat (3) @(negedge clk);
      check_eq("R1 queue drained", q.size(), 0);
      check_eq("R11 hit_count", hit_count, exp_hits);
      check_eq("R11 miss_count", miss_count, exp_miss);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule